// File: doc/BRIEF.md
# Triggered Event Record Formatter

This block turns the data of one triggered event into a stream of fixed 32-bit words. An event opens with a header request. The block answers it with one header word that carries the bunch-crossing number, the event number and a free byte. After that, region entries arrive one by one. Each entry carries a pixel-region address, a 16-bit hit map and sixteen 4-bit charge (time-over-threshold) values.

For every region with at least one hit, the block appends a record to the stream. The record holds the address and the hit map. When charge mode is selected, it also holds the charge values of the hit pixels only. Records have different lengths, so they do not fall on word boundaries. The block packs the bit stream with no gaps, most significant bit first, into an accumulator. It emits a word each time 32 bits are ready.

The last region entry of an event carries an end-of-event flag. When that entry is done, the remaining bits are padded with zeros to a full word and sent. No new entry is taken until that flush is complete. The output uses a valid/ready handshake, and back pressure stalls the block without losing any bits.

Top module: `evt_record_fmt`

## Requirements
- R1: A header request produces 32 bits in the stream: bunch-crossing number (12 bits) in bits 31..20, event number (12 bits) in bits 19..8, and the free byte in bits 7..0, most significant bit first.
- R2: A region entry with a non-zero hit map starts its record with the 14-bit address, followed by the 16-bit hit map, hit-map bit 15 sent first.
- R3: In charge mode (`cfg_binary` = 0), the hit map is followed by one 4-bit charge value for each set hit-map bit, in ascending pixel index. The value of pixel i is `in_tot[4i+3:4i]`, sent MSB first. A record is therefore 34 to 94 bits long.
- R4: In binary mode (`cfg_binary` = 1), a region record is exactly 30 bits (address and hit map), with no charge values.
- R5: The header and the records are concatenated with no gap bits, and each output word holds the next 32 bits of the stream, with its bit 31 being the earliest bit.
- R6: After the entry that carries `in_eoe`, the trailing partial word is filled with zeros in its low bits and emitted. `in_ready` stays low until that word has been accepted, so the next header starts on a word boundary.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value.
- R8: A region entry whose hit map is all zeros is accepted but adds no bits to the stream. If that entry carries `in_eoe`, the event still ends and is flushed.
- R9: After reset, `out_valid` is low and `in_ready` is high.
- R10: An event produces exactly ceil(total bits / 32) words: no bit is dropped, and no extra word is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_binary | input | 1 | 1: records without charge values |
| in_valid | input | 1 | Input entry valid |
| in_ready | output | 1 | Block can accept an entry |
| in_is_hdr | input | 1 | 1: header request, 0: region entry |
| in_eoe | input | 1 | Region entry is the last of its event |
| in_bxid | input | 12 | Bunch-crossing number (header) |
| in_evid | input | 12 | Event number (header) |
| in_misc | input | 8 | Free header byte |
| in_addr | input | 14 | Region address |
| in_map | input | 16 | Region hit map, bit i = pixel i |
| in_tot | input | 64 | Charge values, pixel i in bits 4i+3..4i |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | 32 | Output word, earliest bit in bit 31 |

## Verification
The assertions rely on a few properties of the input stream:
- Every event is bracketed by a header request and a region entry flagged end-of-event.
- No header arrives in the middle of an event.
- `cfg_binary` changes only while the block is idle.

The stimulus respects all three. Its driver sends entries strictly in event order. Before it changes the mode, it waits for `in_ready` after the previous event, and it never raises `in_is_hdr` inside an event.

Under those conditions, header acceptance is checked to coincide with an empty accumulator. The bench also mixes zero hit maps, full maps and random back pressure. These exercise the flush and stall paths at every alignment.

// File: rtl/efmt_pkg.sv
package efmt_pkg;
    localparam int BX_W    = 12;
    localparam int EV_W    = 12;
    localparam int MISC_W  = 8;
    localparam int ADDR_W  = 14;
    localparam int MAP_W   = 16;
    localparam int TOT_W   = 4;
    localparam int WORD_W  = 32;
    localparam int ACC_W   = 2 * WORD_W;
    localparam int TOTS_W  = MAP_W * TOT_W;
    localparam int HEAD_W  = ADDR_W + MAP_W;
    localparam int LEN_W   = $clog2(WORD_W + 1);
    localparam int CNT_W   = $clog2(ACC_W);
    localparam int NHIT_W  = $clog2(MAP_W + 1);
    localparam int TOT_PER_WORD = WORD_W / TOT_W;

    typedef struct packed {
        logic [WORD_W-1:0] bits;   // MSB-aligned, zeros below len
        logic [LEN_W-1:0]  len;
        logic              last;   // final chunk of the entry
    } chunk_t;

    typedef enum logic [2:0] {
        SL_IDLE,
        SL_HDR,
        SL_HEAD,
        SL_TOT_A,
        SL_TOT_B
    } slice_st_e;

    function automatic logic [NHIT_W-1:0] hit_count(input logic [MAP_W-1:0] m);
        logic [NHIT_W-1:0] c;
        c = '0;
        for (int i = 0; i < MAP_W; i++) c = c + NHIT_W'(m[i]);
        return c;
    endfunction

    // Gather charges of hit pixels, lowest pixel index at the top nibble.
    function automatic logic [TOTS_W-1:0] gather_tot(input logic [MAP_W-1:0] m,
                                                     input logic [TOTS_W-1:0] t);
        logic [TOTS_W-1:0] r;
        int k;
        r = '0;
        k = 0;
        for (int i = 0; i < MAP_W; i++) begin
            if (m[i]) begin
                r = r | ({{(TOTS_W-TOT_W){1'b0}}, t[i*TOT_W +: TOT_W]}
                         << (TOTS_W - TOT_W - TOT_W * k));
                k = k + 1;
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/efmt_slicer.sv
module efmt_slicer
    import efmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_binary,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_is_hdr,
    input  logic              in_eoe,
    input  logic [BX_W-1:0]   in_bxid,
    input  logic [EV_W-1:0]   in_evid,
    input  logic [MISC_W-1:0] in_misc,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [MAP_W-1:0]  in_map,
    input  logic [TOTS_W-1:0] in_tot,
    input  logic              flushing,
    input  logic              chunk_take,
    output chunk_t            chunk,
    output logic              chunk_valid,
    output logic              flush_req
);
    slice_st_e          st;
    logic [WORD_W-1:0]  hdr_word;
    logic [HEAD_W-1:0]  head_word;
    logic [TOTS_W-1:0]  tot_c;
    logic [NHIT_W-1:0]  n_hit;
    logic               eoe_q;
    logic               bin_q;
    logic               accept;
    logic               empty_map;

    assign in_ready    = (st == SL_IDLE) && !flushing;
    assign accept      = in_valid && in_ready;
    assign empty_map   = (in_map == '0);
    assign chunk_valid = (st != SL_IDLE);
    assign flush_req   = (chunk_take && chunk.last && eoe_q) ||
                         (accept && !in_is_hdr && empty_map && in_eoe);

    always_comb begin
        chunk = '0;
        case (st)
            SL_HDR: begin
                chunk.bits = hdr_word;
                chunk.len  = LEN_W'(WORD_W);
                chunk.last = 1'b1;
            end
            SL_HEAD: begin
                chunk.bits = {head_word, {(WORD_W-HEAD_W){1'b0}}};
                chunk.len  = LEN_W'(HEAD_W);
                chunk.last = bin_q;
            end
            SL_TOT_A: begin
                chunk.bits = tot_c[TOTS_W-1 -: WORD_W];
                chunk.len  = (n_hit > NHIT_W'(TOT_PER_WORD)) ? LEN_W'(WORD_W)
                                                             : LEN_W'(n_hit * TOT_W);
                chunk.last = (n_hit <= NHIT_W'(TOT_PER_WORD));
            end
            SL_TOT_B: begin
                chunk.bits = tot_c[WORD_W-1:0];
                chunk.len  = LEN_W'((n_hit - NHIT_W'(TOT_PER_WORD)) * TOT_W);
                chunk.last = 1'b1;
            end
            default: chunk = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= SL_IDLE;
            hdr_word  <= '0;
            head_word <= '0;
            tot_c     <= '0;
            n_hit     <= '0;
            eoe_q     <= 1'b0;
            bin_q     <= 1'b0;
        end else if (accept) begin
            if (in_is_hdr) begin
                st       <= SL_HDR;
                hdr_word <= {in_bxid, in_evid, in_misc};
                eoe_q    <= 1'b0;
            end else if (!empty_map) begin
                st        <= SL_HEAD;
                head_word <= {in_addr, in_map};
                tot_c     <= gather_tot(in_map, in_tot);
                n_hit     <= hit_count(in_map);
                eoe_q     <= in_eoe;
                bin_q     <= cfg_binary;
            end
        end else if (chunk_take) begin
            if (chunk.last) st <= SL_IDLE;
            else if (st == SL_HEAD) st <= SL_TOT_A;
            else st <= SL_TOT_B;
        end
    end
endmodule

// File: rtl/efmt_packer.sv
module efmt_packer
    import efmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  chunk_t            chunk,
    input  logic              chunk_valid,
    output logic              chunk_take,
    input  logic              flush_req,
    output logic              flushing,
    output logic [CNT_W-1:0]  pend_cnt,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data
);
    logic [ACC_W-1:0] acc;
    logic [CNT_W-1:0] cnt;
    logic             flush_q;
    logic             fire;
    logic             full_word;

    assign full_word  = (cnt >= CNT_W'(WORD_W));
    assign out_valid  = full_word || (flush_q && cnt != '0);
    assign out_data   = acc[ACC_W-1 -: WORD_W];
    assign fire       = out_valid && out_ready;
    assign chunk_take = chunk_valid && !flush_q && !full_word;
    assign flushing   = flush_q;
    assign pend_cnt   = cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc     <= '0;
            cnt     <= '0;
            flush_q <= 1'b0;
        end else begin
            if (fire) begin
                acc <= acc << WORD_W;
                cnt <= full_word ? cnt - CNT_W'(WORD_W) : '0;
            end else if (chunk_take) begin
                acc <= acc | ({chunk.bits, {(ACC_W-WORD_W){1'b0}}} >> cnt);
                cnt <= cnt + CNT_W'(chunk.len);
            end
            if (flush_req)
                flush_q <= 1'b1;
            else if (flush_q && cnt == '0)
                flush_q <= 1'b0;
        end
    end
endmodule

// File: rtl/evt_record_fmt.sv
module evt_record_fmt
    import efmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_binary,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_is_hdr,
    input  logic              in_eoe,
    input  logic [BX_W-1:0]   in_bxid,
    input  logic [EV_W-1:0]   in_evid,
    input  logic [MISC_W-1:0] in_misc,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [MAP_W-1:0]  in_map,
    input  logic [TOTS_W-1:0] in_tot,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data
);
    chunk_t           chunk;
    logic             chunk_valid;
    logic             chunk_take;
    logic             flush_req;
    logic             flushing;
    logic [CNT_W-1:0] pend_cnt;

    efmt_slicer u_slice (
        .clk(clk), .rst(rst), .cfg_binary(cfg_binary),
        .in_valid(in_valid), .in_ready(in_ready), .in_is_hdr(in_is_hdr),
        .in_eoe(in_eoe), .in_bxid(in_bxid), .in_evid(in_evid),
        .in_misc(in_misc), .in_addr(in_addr), .in_map(in_map), .in_tot(in_tot),
        .flushing(flushing), .chunk_take(chunk_take), .chunk(chunk),
        .chunk_valid(chunk_valid), .flush_req(flush_req)
    );

    efmt_packer u_pack (
        .clk(clk), .rst(rst), .chunk(chunk), .chunk_valid(chunk_valid),
        .chunk_take(chunk_take), .flush_req(flush_req), .flushing(flushing),
        .pend_cnt(pend_cnt), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );
endmodule

// File: rtl/evt_record_fmt_chk.sv
module evt_record_fmt_chk
    import efmt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cfg_binary,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_is_hdr,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_data,
    input logic              chunk_take,
    input chunk_t            chunk,
    input logic              flushing,
    input logic [CNT_W-1:0]  pend_cnt
);
    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data)); // R7

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid && in_ready); // R9

    AST_FLUSH_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        $fell(flushing) |-> pend_cnt == '0); // R6

    AST_HDR_ON_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && in_is_hdr |-> pend_cnt == '0); // R6

    AST_NO_EMPTY_CHUNK: assert property (@(posedge clk) disable iff (rst)
        chunk_take |-> chunk.len != '0); // R8

    AST_BINARY_LEN: assert property (@(posedge clk) disable iff (rst)
        chunk_take && cfg_binary |-> chunk.len == LEN_W'(HEAD_W) ||
                                     chunk.len == LEN_W'(WORD_W)); // R4
endmodule

bind evt_record_fmt evt_record_fmt_chk u_chk (
    .clk(clk), .rst(rst), .cfg_binary(cfg_binary), .in_valid(in_valid),
    .in_ready(in_ready), .in_is_hdr(in_is_hdr), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .chunk_take(chunk_take),
    .chunk(chunk), .flushing(flushing), .pend_cnt(pend_cnt)
);

// File: tb/evt_record_fmt_tb.sv
module evt_record_fmt_tb;
    import efmt_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_binary = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic              in_is_hdr = 1'b0;
    logic              in_eoe = 1'b0;
    logic [BX_W-1:0]   in_bxid = '0;
    logic [EV_W-1:0]   in_evid = '0;
    logic [MISC_W-1:0] in_misc = '0;
    logic [ADDR_W-1:0] in_addr = '0;
    logic [MAP_W-1:0]  in_map = '0;
    logic [TOTS_W-1:0] in_tot = '0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [WORD_W-1:0] out_data;

    int n_tests = 0;
    int n_fail  = 0;
    int ready_pct = 100;
    bit finished = 1'b0;

    bit                bq[$];
    logic [WORD_W-1:0] exp_q[$];
    string             tag_q[$];
    string             cur_tag = "R1";

    always #5 clk = ~clk;

    evt_record_fmt u_dut (
        .clk(clk), .rst(rst), .cfg_binary(cfg_binary), .in_valid(in_valid),
        .in_ready(in_ready), .in_is_hdr(in_is_hdr), .in_eoe(in_eoe),
        .in_bxid(in_bxid), .in_evid(in_evid), .in_misc(in_misc),
        .in_addr(in_addr), .in_map(in_map), .in_tot(in_tot),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    task automatic push_bits(input logic [WORD_W-1:0] v, input int n);
        for (int k = n - 1; k >= 0; k--) bq.push_back(v[k]);
    endtask

    task automatic drain_words();
        while (bq.size() >= WORD_W) begin
            logic [WORD_W-1:0] w;
            for (int k = WORD_W - 1; k >= 0; k--) w[k] = bq.pop_front();
            exp_q.push_back(w);
            tag_q.push_back(cur_tag);
        end
    endtask

    task automatic handshake();
        in_valid = 1'b1;
        while (1) begin
            if (in_ready) begin
                @(posedge clk);
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!in_ready) @(negedge clk);
    endtask

    task automatic send_header(input logic [11:0] bx, input logic [11:0] ev,
                               input logic [7:0] misc);
        push_bits({bx, ev, misc}, 32);   // R1 layout
        drain_words();
        in_is_hdr = 1'b1; in_eoe = 1'b0;
        in_bxid = bx; in_evid = ev; in_misc = misc;
        handshake();
    endtask

    task automatic send_region(input logic [13:0] addr, input logic [15:0] map,
                               input logic [63:0] tot, input bit eoe);
        if (map != 0) begin
            push_bits(32'(addr), 14);            // R2
            push_bits(32'(map), 16);
            if (!cfg_binary)                     // R3 ascending pixel order
                for (int i = 0; i < 16; i++)
                    if (map[i]) push_bits(32'(tot[4*i +: 4]), 4);
        end
        if (eoe) begin                           // R6 zero pad
            while (bq.size() % WORD_W != 0) bq.push_back(1'b0);
        end
        drain_words();
        in_is_hdr = 1'b0; in_eoe = eoe;
        in_addr = addr; in_map = map; in_tot = tot;
        handshake();
        in_eoe = 1'b0;
    endtask

    // Monitor / scoreboard; owns out_ready
    bit                prev_stall = 1'b0;
    logic [WORD_W-1:0] prev_data;
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_stall) begin
                n_tests++;
                if (!(out_valid && out_data == prev_data)) begin
                    n_fail++;
                    $display("FAIL R7 stall hold: valid=%0b data=%h expected data=%h",
                             out_valid, out_data, prev_data);
                end
            end
            out_ready = ($urandom_range(99) < ready_pct);
            if (out_valid && out_ready) begin
                n_tests++;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R10 extra word: actual=%h expected=none", out_data);
                end else begin
                    logic [WORD_W-1:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (out_data !== e) begin
                        n_fail++;
                        $display("FAIL %s word: actual=%h expected=%h", t, out_data, e);
                    end
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
        end
    end

    // Watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic check_drained(input string t);
        int guard;
        guard = 0;
        wait_idle();
        while (exp_q.size() != 0 && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        repeat (5) @(negedge clk);
        n_tests++;
        if (exp_q.size() != 0 || out_valid) begin
            n_fail++;
            $display("FAIL %s word count: actual pending=%0d valid=%0b expected 0 0",
                     t, exp_q.size(), out_valid);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        n_tests++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            n_fail++;
            $display("FAIL R9 reset: valid=%0b ready=%0b expected 0 1", out_valid, in_ready);
        end

        // One-hit region in charge mode
        cur_tag = "R1";
        send_header(12'hABC, 12'h123, 8'h5A);
        cur_tag = "R2";
        send_region(14'h2AAA, 16'h0010, 64'h0000_0000_000F_0000, 1'b1);
        check_drained("R10");

        // Full map then a 3-hit region, with back pressure
        ready_pct = 40;
        cur_tag = "R3";
        send_header(12'h001, 12'h002, 8'h03);
        send_region(14'h1234, 16'hFFFF, 64'h0123_4567_89AB_CDEF, 1'b0);
        cur_tag = "R5";
        send_region(14'h0F0F, 16'h8101, 64'h9000_0000_0000_00A5, 1'b1);
        check_drained("R5");

        // Zero map in the middle and as the ending entry
        cur_tag = "R8";
        send_header(12'h777, 12'h888, 8'h99);
        send_region(14'h3FFF, 16'h0000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
        send_region(14'h0001, 16'h0003, 64'h0000_0000_0000_0021, 1'b0);
        send_region(14'h0002, 16'h0000, 64'h1111_1111_1111_1111, 1'b1);
        check_drained("R8");

        // Binary mode
        wait_idle();
        cfg_binary = 1'b1;
        cur_tag = "R4";
        send_header(12'h0F0, 12'h00F, 8'hC3);
        send_region(14'h1555, 16'hA5A5, 64'hDEAD_BEEF_0000_1111, 1'b0);
        send_region(14'h0AAA, 16'h0001, 64'h0000_0000_0000_000E, 1'b0);
        send_region(14'h2001, 16'h8000, 64'h7000_0000_0000_0000, 1'b1);
        check_drained("R4");

        // Random events, both modes, back pressure
        cur_tag = "R5";
        for (int e = 0; e < 40; e++) begin
            int nreg;
            wait_idle();
            cfg_binary = ($urandom_range(3) == 0);
            ready_pct = 30 + $urandom_range(70);
            send_header(12'($urandom), 12'($urandom), 8'($urandom));
            nreg = 1 + $urandom_range(4);
            for (int r = 0; r < nreg; r++) begin
                logic [15:0] m;
                m = ($urandom_range(4) == 0) ? 16'h0 : 16'($urandom);
                send_region(14'($urandom), m, {$urandom, $urandom}, r == nreg - 1);
            end
        end
        check_drained("R10");

        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule